// File: doc/BRIEF.md
# General-Purpose I/O Bank with Strobed Output Updates

This block is one bank of general-purpose pins behind a small register port. Each pin owns one bit in every register. A direction word chooses, per pin, whether the output driver is on. An output latch drives the pad value. Software never writes that latch as a whole word. It updates the latch through two strobe addresses: one raises the pins whose write bits are 1, and the other lowers them. Single pins can therefore change without a read-modify-write, and two agents that each touch their own pins do not interfere.

The pad inputs pass through a two-stage synchronizer into the bank clock domain. The input-level address returns the synchronized level of every pin, including pins that are currently driven as outputs, so software can read back what is on the wire. Because of the synchronizer, a read issued right after the pad changes still returns the earlier level. A bank can be built with fewer valid pins than its word width. The bits above the valid count are inert.

Reads are registered. The data for a read presented on one rising edge appears on `rdData` after that edge and holds until the next read.

Top module: `gpio_strobe_bank`

## Requirements
- R1: After reset, every valid direction bit is 1 (input), the output latch is 0, `padOut` is 0 and `padOutEn` is 0.
- R2: A write to word address 1 (set strobe) drives to 1 every valid output latch bit whose write bit is 1. Latch bits with a write bit of 0 keep their value.
- R3: A write to word address 2 (clear strobe) drives to 0 every valid output latch bit whose write bit is 1. Latch bits with a write bit of 0 keep their value.
- R4: Word address 0 is the direction register. It is read/write, where bit value 1 means input and 0 means output. `padOutEn[i]` is the inverse of direction bit i for valid pins, and it changes only on a direction write.
- R5: A read of word address 3 returns the synchronized pad level of each valid pin, whatever its direction. A write to address 3 changes no state.
- R6: The synchronizer has two stages. After a pad change, reads sampled on the first and second rising edges still return the previous level. A read sampled on the third edge or later returns the new level.
- R7: Pins at index VALID_PINS and above read as 0 at every address, ignore every write, and never drive `padOut` or `padOutEn`.
- R8: A read of address 1 or address 2 returns the current output latch. Read data appears one cycle after the read is sampled and then holds.
- R9: `padOut` shows the output latch whatever the direction bits are, so a value loaded before a pin is turned into an output appears at once when the driver turns on. The latch changes only through the set and clear strobes.
- R10: When a read and a write are sampled on the same edge, the read returns the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request, sampled on the rising edge |
| rdEn | input | 1 | Read request, sampled on the rising edge |
| regAddr | input | 2 | Word address: 0 direction, 1 set strobe, 2 clear strobe, 3 input level |
| wrData | input | PIN_COUNT | Write data, one bit per pin |
| rdData | output | PIN_COUNT | Registered read data |
| padIn | input | PIN_COUNT | Raw pad levels, asynchronous to clk |
| padOut | output | PIN_COUNT | Output latch value to the pads |
| padOutEn | output | PIN_COUNT | Per-pin output-driver enable, 1 means driven |

## Verification
The hardest case to reach from the ports is the synchronizer window. A pad change has to be followed by reads on exactly the first, second and third edges after it, so that the stale and fresh returns can each be seen. The bench changes `padIn` on a falling edge and then issues three reads back to back without an idle cycle. It expects the old level twice and then the new level. It does this on a pattern in which some of the pins are already outputs, and the pattern includes bits above the valid pin count.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DIR   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SET   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CLR   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_LEVEL = 2'd3;

  typedef enum logic [1:0] {
    SRC_DIR   = 2'd0,
    SRC_LATCH = 2'd1,
    SRC_LEVEL = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic   dirWrite;
    logic   setWrite;
    logic   clrWrite;
    logic   rdLoad;
    rdSrc_e rdSrc;
  } bankCtl_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output bankCtl_t          ctl
);

  always_comb begin
    ctl          = '0;
    ctl.rdSrc    = SRC_DIR;
    ctl.dirWrite = wrEn && (regAddr == ADDR_DIR);
    ctl.setWrite = wrEn && (regAddr == ADDR_SET);
    ctl.clrWrite = wrEn && (regAddr == ADDR_CLR);
    ctl.rdLoad   = rdEn;
    unique case (regAddr)
      ADDR_DIR:   ctl.rdSrc = SRC_DIR;
      ADDR_SET,
      ADDR_CLR:   ctl.rdSrc = SRC_LATCH;
      ADDR_LEVEL: ctl.rdSrc = SRC_LEVEL;
      default:    ctl.rdSrc = SRC_DIR;
    endcase
  end

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int VALID_PINS  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankCtl_t             ctl,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] rdData,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOutEn
);

  logic [PIN_COUNT-1:0] dirVec;
  logic [PIN_COUNT-1:0] latchVec;
  logic [PIN_COUNT-1:0] levelVec;

  for (genvar i = 0; i < PIN_COUNT; i++) begin : gPin
    if (i < VALID_PINS) begin : gLive
      logic                   dirQ;
      logic                   latchQ;
      logic [SYNC_STAGES-1:0] syncQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          dirQ   <= 1'b1;
          latchQ <= 1'b0;
          syncQ  <= '0;
        end else begin
          syncQ <= {syncQ[SYNC_STAGES-2:0], padIn[i]};
          if (ctl.dirWrite) dirQ <= wrData[i];
          if (ctl.setWrite && wrData[i])      latchQ <= 1'b1;
          else if (ctl.clrWrite && wrData[i]) latchQ <= 1'b0;
        end
      end

      assign dirVec[i]   = dirQ;
      assign latchVec[i] = latchQ;
      assign levelVec[i] = syncQ[SYNC_STAGES-1];
    end else begin : gDead
      logic unusedPin;
      assign unusedPin   = padIn[i] ^ wrData[i];
      assign dirVec[i]   = 1'b0;
      assign latchVec[i] = 1'b0;
      assign levelVec[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.rdLoad) begin
      unique case (ctl.rdSrc)
        SRC_DIR:   rdData <= dirVec;
        SRC_LATCH: rdData <= latchVec;
        SRC_LEVEL: rdData <= levelVec;
        default:   rdData <= '0;
      endcase
    end
  end

  localparam logic [PIN_COUNT-1:0] LIVE_MASK =
    {PIN_COUNT{1'b1}} >> (PIN_COUNT - VALID_PINS);

  assign padOut   = latchVec;
  assign padOutEn = ~dirVec & LIVE_MASK;

endmodule

// File: rtl/gpio_strobe_bank.sv
module gpio_strobe_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int VALID_PINS  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [PIN_COUNT-1:0] wrData,
  output logic [PIN_COUNT-1:0] rdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOutEn
);

  bankCtl_t ctl;

  gpio_bank_ctrl uCtrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .regAddr (regAddr),
    .ctl     (ctl)
  );

  gpio_bank_datapath #(
    .PIN_COUNT   (PIN_COUNT),
    .VALID_PINS  (VALID_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrData   (wrData),
    .padIn    (padIn),
    .rdData   (rdData),
    .padOut   (padOut),
    .padOutEn (padOutEn)
  );

endmodule

// File: rtl/gpio_strobe_bank_chk.sv
module gpio_strobe_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT  = 32,
  parameter int VALID_PINS = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [PIN_COUNT-1:0] wrData,
  input logic [PIN_COUNT-1:0] rdData,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padOutEn
);

  localparam logic [PIN_COUNT-1:0] LIVE =
    {PIN_COUNT{1'b1}} >> (PIN_COUNT - VALID_PINS);

  a_r2_set_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_SET) |=> padOut == ($past(padOut) | ($past(wrData) & LIVE)));

  a_r3_clear_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_CLR) |=> padOut == ($past(padOut) & ~$past(wrData)));

  a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (regAddr == ADDR_SET || regAddr == ADDR_CLR)) |=> $stable(padOut));

  a_r4_enable_follows: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_DIR) |=> padOutEn == (~$past(wrData) & LIVE));

  a_r4_enable_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regAddr == ADDR_DIR) |=> $stable(padOutEn));

  a_r7_unused_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((padOut | padOutEn | rdData) & ~LIVE) == '0);

endmodule

bind gpio_strobe_bank gpio_strobe_bank_chk #(
  .PIN_COUNT  (PIN_COUNT),
  .VALID_PINS (VALID_PINS)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .regAddr  (regAddr),
  .wrData   (wrData),
  .rdData   (rdData),
  .padOut   (padOut),
  .padOutEn (padOutEn)
);

// File: tb/sim_gpio_strobe_bank.sv
`timescale 1ns/1ps
module sim_gpio_strobe_bank;

  localparam int W = 32;
  localparam int VP = 28;
  localparam logic [W-1:0] M = 32'h0FFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] padIn = '0;
  logic [W-1:0] rdData, padOut, padOutEn;

  always #2.5 clk = ~clk;

  gpio_strobe_bank #(.PIN_COUNT(W), .VALID_PINS(VP)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .padIn(padIn),
    .padOut(padOut), .padOutEn(padOutEn)
  );

  int checks = 0;
  int errors = 0;
  logic [W-1:0] expQ[$];
  string tagQ[$];
  logic monArm = 1'b0;
  logic [W-1:0] mDir, mLatch;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads as they emerge on rdData
  always @(negedge clk) begin
    if (monArm) begin
      monArm = 1'b0;
      if (expQ.size() == 0) begin
        check("scoreboard-empty", rdData, '0);
      end else begin
        check(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  // all tasks start and end on a falling edge
  task automatic doWrite(input logic [1:0] a, input logic [W-1:0] d);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 2'd0) mDir = d & M;
    else if (a == 2'd1) mLatch = mLatch | (d & M);
    else if (a == 2'd2) mLatch = mLatch & ~d;
  endtask

  task automatic doRead(input logic [1:0] a, input logic [W-1:0] exp, input string tag);
    rdEn = 1'b1; regAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(posedge clk);
    #1 monArm = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    mDir = M; mLatch = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 padOut after reset", padOut, '0);
    check("R1 padOutEn after reset", padOutEn, '0);
    doRead(2'd0, M, "R1 direction reset");
    doRead(2'd1, '0, "R1 latch reset");

    // R2 set strobe
    doWrite(2'd1, 32'h0000_00F5);
    check("R2 padOut after set", padOut, 32'h0000_00F5);
    doRead(2'd1, 32'h0000_00F5, "R8 latch via set addr");
    doWrite(2'd1, 32'h0300_0003);
    check("R2 zero bits unchanged", padOut, 32'h0300_00F7);

    // R3 clear strobe
    doWrite(2'd2, 32'h0000_0011);
    check("R3 padOut after clear", padOut, 32'h0300_00E6);
    doRead(2'd2, 32'h0300_00E6, "R8 latch via clear addr");
    doWrite(2'd2, 32'h0);
    check("R3 zero word no change", padOut, 32'h0300_00E6);

    // R4 direction, R9 latch independent of direction
    check("R9 latch shown while inputs", padOut, mLatch);
    doWrite(2'd0, 32'hFFFF_0F0F);
    check("R4 padOutEn inverse of dir", padOutEn, 32'h0000_F0F0);
    check("R9 padOut kept across dir write", padOut, 32'h0300_00E6);
    doRead(2'd0, 32'h0FFF_0F0F, "R7 dir upper bits read zero");

    // R7 unused pins ignore set
    doWrite(2'd1, 32'hFFFF_FFFF);
    check("R7 unused pins not driven", padOut, M);
    doRead(2'd1, M, "R7 latch upper bits zero");
    doWrite(2'd2, 32'hFFFF_FFFF);
    check("R3 clear all", padOut, '0);

    // R5 / R6 input level through synchronizer, mixed directions
    padIn = 32'h1234_5678;
    repeat (4) @(negedge clk);
    doRead(2'd3, 32'h0234_5678, "R5 level read");
    padIn = 32'hA5A5_5A5A;
    doRead(2'd3, 32'h0234_5678, "R6 first edge old");
    doRead(2'd3, 32'h0234_5678, "R6 second edge old");
    doRead(2'd3, 32'h05A5_5A5A, "R6 third edge new");
    doRead(2'd3, 32'h05A5_5A5A, "R5 level on output pins");

    // R5 write to level address ignored
    doWrite(2'd3, 32'hFFFF_FFFF);
    doRead(2'd0, mDir, "R5 level write leaves dir");
    doRead(2'd1, mLatch, "R5 level write leaves latch");
    check("R5 level write leaves padOut", padOut, '0);

    // R10 read and write on the same edge
    wrEn = 1'b1; rdEn = 1'b1; regAddr = 2'd0; wrData = 32'h0000_FFFF;
    expQ.push_back(mDir); tagQ.push_back("R10 read returns pre-write");
    @(posedge clk);
    #1 monArm = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; mDir = 32'h0000_FFFF;
    doRead(2'd0, 32'h0000_FFFF, "R10 write took effect");
    check("R4 padOutEn after new dir", padOutEn, 32'h0FFF_0000);

    // R9 preload then enable
    doWrite(2'd1, 32'h0000_0100);
    check("R9 preload not yet driven", padOutEn & 32'h100, 32'h0);
    doWrite(2'd0, 32'h0000_FEFF);
    check("R9 driven with preloaded value", padOut & padOutEn & 32'h100, 32'h100);

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) check("scoreboard drained", 32'(expQ.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule